// File: doc/BRIEF.md
# CPU Power Mode and Clock Divider Controller

This block decides how fast the CPU core runs and whether it runs at all. It produces a CPU clock enable that lets the core advance on every system clock, or on one clock out of 2, 4, 8, 16 or 32. It also reports one of five operating modes: reset, high-speed, medium-speed, sleep and software standby. Peripherals that are not bus masters keep a full-rate clock enable. That enable drops only in software standby and in reset.

The speed is chosen by a 3-bit divider field held in a control register. A new divider value takes effect only on a cycle where the bus interface flags the end of a bus cycle. A sleep request strobe from the CPU enters sleep or software standby. Which of the two it enters, or whether the request is dropped, is decided by three register bits: the standby enable, the subclock select and the watchdog select. A wake-up returns the core to the speed it had before. A watchdog overflow forces the reset state from any mode. So does the asynchronous active-low reset pin, which is asserted at once and released through a two-stage synchronizer.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While the reset pin is low, `mode` is 0 (reset) and both clock enables are low. After release the block passes through reset and settles in high-speed mode. High-speed is `mode` 1, with `cpu_div_code` 0 and both enables high on every cycle.
- R2: A change of `div_sel` is applied only on a clock edge where `bus_end` is high. A nonzero value gives medium-speed mode (`mode` 2), and the value 000 returns to high-speed mode. Until then, mode and `cpu_div_code` keep their old values.
- R3: The divider encoding is 000 divide by 1, 001 by 2, 010 by 4, 011 by 8, 100 by 16 and 101 by 32. Codes 110 and 111 divide by 32. `cpu_div_code` shows the applied code.
- R4: In medium-speed mode with divide ratio N, `cpu_clk_en` is a single-cycle pulse every N system clocks. The first pulse comes in the N-th cycle after medium-speed mode is entered or the ratio changes. For example, with divide by 4 two CPU states span 8 system clocks.
- R5: `per_clk_en` is high in high-speed, medium-speed and sleep modes, whatever the divider setting.
- R6: `sleep_req` with `stby_en`=0 and `sub_sel`=0 enters sleep (`mode` 3) on the next edge. In sleep `cpu_clk_en` is low. Either interrupt input returns the block to the prior speed mode with its divider unchanged.
- R7: `sleep_req` with `stby_en`=1, `sub_sel`=0 and `wdt_sel`=0 enters software standby (`mode` 4), where both enables are low. `irq_int` has no effect there. Only `irq_ext` returns the block to the prior speed mode.
- R8: A `sleep_req` with `sub_sel`=1 is ignored, and so is one with `stby_en`=1 and `wdt_sel`=1. In both cases the mode stays unchanged.
- R9: `wdt_ovf` forces reset mode on the next edge from any mode and clears the applied divider to 000. One cycle later the block is in high-speed mode.
- R10: When `sleep_req` and `bus_end` are high on the same edge, the sleep request wins and the divider is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| div_sel | input | 3 | CPU clock divider select from the control register |
| stby_en | input | 1 | Standby enable bit |
| sub_sel | input | 1 | Subclock select bit |
| wdt_sel | input | 1 | Watchdog select bit |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| bus_end | input | 1 | End of the current bus cycle |
| irq_int | input | 1 | Internal interrupt request |
| irq_ext | input | 1 | External interrupt request |
| wdt_ovf | input | 1 | Watchdog overflow |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 standby |
| cpu_div_code | output | 3 | Divider code in force |

## Verification
The divider is exercised with every code from 001 to 111. Each code is entered with a `bus_end` pulse and its enable pattern is compared cycle by cycle. This tells the saturation of codes 110 and 111 apart from a wrapped shift, and a restarted phase apart from a free-running one. A divider value is also held without `bus_end` for several cycles, which tells a deferred update from an immediate one. Sleep and standby are entered from both high-speed and medium-speed modes. Each is woken by both interrupt kinds, so that the return target and the standby-only wake rule are separated. The two ignored request combinations are tried, along with a request that coincides with `bus_end`, a watchdog overflow, and a reset pulled in the middle of standby.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;
  typedef enum logic [2:0] {
    PM_RESET   = 3'd0,
    PM_HIGH    = 3'd1,
    PM_MEDIUM  = 3'd2,
    PM_SLEEP   = 3'd3,
    PM_STANDBY = 3'd4
  } pwr_mode_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_clk_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             stby_en,
  input  logic             sub_sel,
  input  logic             wdt_sel,
  input  logic             sleep_req,
  input  logic             bus_end,
  input  logic             irq_int,
  input  logic             irq_ext,
  input  logic             wdt_ovf,
  output pwr_mode_e        mode_q,
  output pwr_mode_e        mode_nxt,
  output logic [SEL_W-1:0] code_q,
  output logic             restart
);
  logic [SEL_W-1:0] code_nxt;
  logic             sleep_ok;
  pwr_mode_e        speed_mode;

  // the speed mode to resume follows from the divider still in force
  assign speed_mode = (code_q == '0) ? PM_HIGH : PM_MEDIUM;
  assign sleep_ok   = sleep_req && !sub_sel && (!stby_en || !wdt_sel);

  always_comb begin
    mode_nxt = mode_q;
    code_nxt = code_q;
    unique case (mode_q)
      PM_RESET: mode_nxt = PM_HIGH;
      PM_HIGH, PM_MEDIUM: begin
        if (sleep_ok) begin
          mode_nxt = stby_en ? PM_STANDBY : PM_SLEEP;
        end else if (bus_end) begin
          code_nxt = div_sel;
          mode_nxt = (div_sel == '0) ? PM_HIGH : PM_MEDIUM;
        end
      end
      PM_SLEEP: begin
        if (irq_int || irq_ext) mode_nxt = speed_mode;
      end
      PM_STANDBY: begin
        if (irq_ext) mode_nxt = speed_mode;
      end
      default: mode_nxt = PM_RESET;
    endcase
    if (wdt_ovf) begin
      mode_nxt = PM_RESET;
      code_nxt = '0;
    end
  end

  assign restart = (code_nxt != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RESET;
      code_q <= '0;
    end else begin
      mode_q <= mode_nxt;
      code_q <= code_nxt;
    end
  end
endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div
  import pwr_clk_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwr_mode_e        mode_q,
  input  pwr_mode_e        mode_nxt,
  input  logic [SEL_W-1:0] code_q,
  input  logic             restart,
  output logic             tick
);
  localparam int SH_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   tap;
  logic [SH_W-1:0]  shift;
  logic             keep_cnt;

  // tap[i] is high in the last cycle of each 2**i period
  assign tap[0] = 1'b1;
  for (genvar i = 1; i <= CNT_W; i++) begin : g_tap
    assign tap[i] = &cnt_q[i-1:0];
  end

  // codes above the widest ratio saturate to it
  assign shift = (code_q > SEL_W'(CNT_W)) ? SH_W'(CNT_W) : SH_W'(code_q);

  assign keep_cnt = (mode_q == PM_MEDIUM) && (mode_nxt == PM_MEDIUM) && !restart;
  assign cnt_nxt  = keep_cnt ? cnt_q + CNT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign tick = (mode_q == PM_MEDIUM) && tap[shift];
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             stby_en,
  input  logic             sub_sel,
  input  logic             wdt_sel,
  input  logic             sleep_req,
  input  logic             bus_end,
  input  logic             irq_int,
  input  logic             irq_ext,
  input  logic             wdt_ovf,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [2:0]       mode,
  output logic [SEL_W-1:0] cpu_div_code
);
  logic             rst_q_n;
  pwr_mode_e        mode_q, mode_nxt;
  logic [SEL_W-1:0] code_q;
  logic             restart, tick;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  pwr_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst_n(rst_q_n), .div_sel(div_sel), .stby_en(stby_en),
    .sub_sel(sub_sel), .wdt_sel(wdt_sel), .sleep_req(sleep_req),
    .bus_end(bus_end), .irq_int(irq_int), .irq_ext(irq_ext),
    .wdt_ovf(wdt_ovf), .mode_q(mode_q), .mode_nxt(mode_nxt),
    .code_q(code_q), .restart(restart)
  );

  pwr_clk_div #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_q_n), .mode_q(mode_q), .mode_nxt(mode_nxt),
    .code_q(code_q), .restart(restart), .tick(tick)
  );

  assign cpu_clk_en   = (mode_q == PM_HIGH) || tick;
  assign per_clk_en   = (mode_q == PM_HIGH) || (mode_q == PM_MEDIUM) ||
                        (mode_q == PM_SLEEP);
  assign mode         = mode_q;
  assign cpu_div_code = code_q;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic [SEL_W-1:0] cpu_div_code,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             sleep_req,
  input logic             sub_sel,
  input logic             bus_end,
  input logic             irq_ext,
  input logic             wdt_ovf
);
  AST_HIGH_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (cpu_clk_en && per_clk_en));                               // R1

  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_div_code != $past(cpu_div_code)) |-> ($past(bus_end) || $past(wdt_ovf))); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && cpu_clk_en && !bus_end && !wdt_ovf && !sleep_req)
      |=> !cpu_clk_en);                                                            // R4

  AST_SLEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (!cpu_clk_en && per_clk_en));                               // R6

  AST_STANDBY_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (!cpu_clk_en && !per_clk_en));                              // R7

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !irq_ext && !wdt_ovf) |=> (mode == 3'd4));                    // R7

  AST_SUBCLK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd1 || mode == 3'd2) && sleep_req && sub_sel && !bus_end && !wdt_ovf)
      |=> $stable(mode));                                                          // R8

  AST_WDT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> (mode == 3'd0 && cpu_div_code == '0));                             // R9
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .mode(mode), .cpu_div_code(cpu_div_code),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .sleep_req(sleep_req),
  .sub_sel(sub_sel), .bus_end(bus_end), .irq_ext(irq_ext), .wdt_ovf(wdt_ovf)
);

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;
  typedef struct {
    bit         chk;
    logic [2:0] m;
    logic       c;
    logic       p;
    logic [2:0] code;
    string      tag;
  } exp_t;

  logic clk, rst_n;
  logic [2:0] div_sel;
  logic stby_en, sub_sel, wdt_sel, sleep_req, bus_end, irq_int, irq_ext, wdt_ovf;
  logic cpu_clk_en, per_clk_en;
  logic [2:0] mode, cpu_div_code;

  bit p_sleep, p_bus, p_irqi, p_irqe, p_wdt;
  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb_q[$];

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .stby_en(stby_en),
    .sub_sel(sub_sel), .wdt_sel(wdt_sel), .sleep_req(sleep_req),
    .bus_end(bus_end), .irq_int(irq_int), .irq_ext(irq_ext), .wdt_ovf(wdt_ovf),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mode(mode),
    .cpu_div_code(cpu_div_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // driver: applies this cycle's inputs and queues the state expected after the edge
  task automatic cyc(bit chk, logic [2:0] m, logic c, logic p, logic [2:0] code, string tag);
    exp_t e;
    @(negedge clk);
    sleep_req = p_sleep; bus_end = p_bus; irq_int = p_irqi;
    irq_ext = p_irqe;    wdt_ovf = p_wdt;
    p_sleep = 0; p_bus = 0; p_irqi = 0; p_irqe = 0; p_wdt = 0;
    e.chk = chk; e.m = m; e.c = c; e.p = p; e.code = code; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares the registered outputs just after each edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (e.chk) begin
        total++;
        if ({mode, cpu_clk_en, per_clk_en, cpu_div_code} !== {e.m, e.c, e.p, e.code}) begin
          bad++;
          $display("FAIL %s: actual mode=%0d cpu=%0b per=%0b code=%0d expected mode=%0d cpu=%0b per=%0b code=%0d",
                   e.tag, mode, cpu_clk_en, per_clk_en, cpu_div_code, e.m, e.c, e.p, e.code);
        end
      end
    end
  end

  task automatic chk_now(string tag, logic [2:0] m, logic c, logic p);
    total++;
    if ({mode, cpu_clk_en, per_clk_en} !== {m, c, p}) begin
      bad++;
      $display("FAIL %s: actual mode=%0d cpu=%0b per=%0b expected mode=%0d cpu=%0b per=%0b",
               tag, mode, cpu_clk_en, per_clk_en, m, c, p);
    end
  endtask

  function automatic int ratio(logic [2:0] code);
    return 1 << ((code > 3'd5) ? 5 : int'(code));
  endfunction

  // expected enable in the k-th cycle (k from 0) of medium-speed mode
  function automatic logic pulse_at(int k, logic [2:0] code);
    return (k % ratio(code)) == ratio(code) - 1;
  endfunction

  task automatic warmup();
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "warmup");
  endtask

  // enter a divider at a bus boundary and follow its pattern
  task automatic run_med(logic [2:0] code, int n, string tag);
    div_sel = code; p_bus = 1;
    for (int k = 0; k < n; k++) cyc(1, 3'd2, pulse_at(k, code), 1, code, tag);
  endtask

  initial begin
    rst_n = 0; div_sel = 0; stby_en = 0; sub_sel = 0; wdt_sel = 0;
    sleep_req = 0; bus_end = 0; irq_int = 0; irq_ext = 0; wdt_ovf = 0;
    p_sleep = 0; p_bus = 0; p_irqi = 0; p_irqe = 0; p_wdt = 0;
    repeat (3) @(posedge clk);
    #1 chk_now("R1 reset held", 3'd0, 0, 0);
    @(negedge clk); rst_n = 1;
    warmup();
    for (int i = 0; i < 4; i++) cyc(1, 3'd1, 1, 1, 0, "R1 high-speed");

    // R2: divider written but no bus boundary yet
    div_sel = 3'd2;
    for (int i = 0; i < 3; i++) cyc(1, 3'd1, 1, 1, 0, "R2 held without bus_end");
    // R4/R5: divide by 4, two CPU states in 8 system clocks
    run_med(3'd2, 12, "R4 div4 pattern");
    // R3: every nonzero code, including the saturated ones
    run_med(3'd1, 6,  "R3 code 001");
    run_med(3'd3, 17, "R3 code 011");
    run_med(3'd4, 33, "R3 code 100");
    run_med(3'd5, 65, "R3 code 101");
    run_med(3'd6, 33, "R3 code 110");
    run_med(3'd7, 33, "R3 code 111");
    // R4: change /8 -> /2 mid-period, the phase restarts
    run_med(3'd3, 5, "R4 div8 partial");
    run_med(3'd1, 6, "R4 restart to div2");

    // R6: sleep from medium /4, interrupt returns to medium with same divider
    run_med(3'd2, 3, "R6 pre-sleep");
    stby_en = 0; p_sleep = 1;
    for (int i = 0; i < 3; i++) cyc(1, 3'd3, 0, 1, 3'd2, "R6 sleep R5 per on");
    p_irqi = 1;
    for (int k = 0; k < 8; k++) cyc(1, 3'd2, pulse_at(k, 3'd2), 1, 3'd2, "R6 wake medium");

    // R7: standby; internal irq ignored, external wakes
    stby_en = 1; wdt_sel = 0; p_sleep = 1;
    cyc(1, 3'd4, 0, 0, 3'd2, "R7 standby entry");
    p_irqi = 1;
    cyc(1, 3'd4, 0, 0, 3'd2, "R7 irq_int ignored");
    cyc(1, 3'd4, 0, 0, 3'd2, "R7 standby hold");
    p_irqe = 1;
    for (int k = 0; k < 4; k++) cyc(1, 3'd2, pulse_at(k, 3'd2), 1, 3'd2, "R7 wake medium");

    // back to high speed at a boundary
    div_sel = 0; p_bus = 1;
    cyc(1, 3'd1, 1, 1, 0, "R2 return to high");

    // R8: ignored requests
    stby_en = 0; sub_sel = 1; p_sleep = 1;
    cyc(1, 3'd1, 1, 1, 0, "R8 subclock set ignored");
    cyc(1, 3'd1, 1, 1, 0, "R8 still high");
    sub_sel = 0; stby_en = 1; wdt_sel = 1; p_sleep = 1;
    cyc(1, 3'd1, 1, 1, 0, "R8 standby with wdt_sel ignored");
    cyc(1, 3'd1, 1, 1, 0, "R8 still high");

    // R10: sleep and bus_end together; R6 wake to high
    stby_en = 0; wdt_sel = 0; div_sel = 3'd3; p_bus = 1; p_sleep = 1;
    cyc(1, 3'd3, 0, 1, 0, "R10 sleep wins over bus_end");
    p_irqe = 1;
    cyc(1, 3'd1, 1, 1, 0, "R6 wake to high");
    div_sel = 0;

    // R9: watchdog from medium
    run_med(3'd3, 4, "R9 pre-overflow");
    p_wdt = 1;
    cyc(1, 3'd0, 0, 0, 0, "R9 overflow reset");
    div_sel = 0;
    cyc(1, 3'd1, 1, 1, 0, "R9 back to high");

    // R1: reset pin in standby
    stby_en = 1; p_sleep = 1;
    cyc(1, 3'd4, 0, 0, 0, "R7 standby from high");
    @(negedge clk); rst_n = 0;
    #1 chk_now("R1 async reset in standby", 3'd0, 0, 0);
    @(negedge clk); rst_n = 1; stby_en = 0;
    warmup();
    cyc(1, 3'd1, 1, 1, 0, "R1 high after reset");
    cyc(0, 0, 0, 0, 0, "drain");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule